// File: doc/BRIEF.md
# Colour LCD Controller Register and Frame Interrupt Block

This block is the register file of a colour LCD controller. It sits on a simple 32-bit bus that is addressed by word index and has separate read and write strobes. It holds four panel timing words, two frame-buffer base addresses (upper and lower panel), a control word and an interrupt mask. It also holds a two-bit interrupt status that can be read raw or masked and cleared by writing ones. A read-only identification window at the top of the map returns one byte per word.

From these registers the block derives the active pixels per line and the lines per frame. It decodes the control word into an enable that needs both the enable and the power bit, the pixel depth code, and the colour and endianness selects. These outputs feed the pixel fetch and panel timing logic that sit beside it.

An internal frame tick runs only while the controller is enabled. Its period in clock cycles is a parameter, and rewriting the control word with the controller enabled restarts that period. Each tick sets the next-base and vertical-compare status bits together. One level interrupt output is high while any status bit is also set in the mask. A variant parameter swaps the word indices of the control and mask registers and selects the identification bytes.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every register is zero, irq_o and enabled_o are low, ppl_o reads 16 and lpf_o reads 1.
- R2: Word indices 0 to 3 (timing), 4 (upper base) and 5 (lower base) read back the last 32-bit value written, and indices 11 and 12 return the upper and lower base values.
- R3: ppl_o equals ((timing0 & 0xFC) + 4) * 4 and lpf_o equals timing1[9:0] + 1.
- R4: Control bits decode as bit 0 enable, bits 3:1 depth code (bpp_o), bit 8 colour swap (bgr_o), bit 9 big-endian bytes (be_byte_o), bit 10 big-endian pixels in a byte (be_pix_o), bit 11 power; enabled_o is high only when bits 0 and 11 are both set.
- R5: With VARIANT = VAR_BASE, index 6 is the mask and index 7 is control; with any other variant the two indices are swapped, for reads and writes alike.
- R6: While enabled, a frame tick every TICK_CYCLES cycles sets status bits 2 and 3; while not enabled no tick occurs and the count restarts; a control write restarts the period, so the first tick comes TICK_CYCLES edges after the write edge.
- R7: Index 8 reads the raw status (bits 2 and 3), index 9 reads raw status AND mask, and irq_o is high exactly when that masked value is nonzero.
- R8: A write to index 10 clears each status bit written as one; when a tick and a clear fall on the same edge, the tick wins and both bits end up set.
- R9: Indices 0x3F8 to 0x3FF return one byte each, zero-extended: 10 11 04 00 0D F0 05 B1 (hex, ascending index) for VAR_BASE and VAR_BOARD, and 11 11 24 00 0D F0 05 B1 for VAR_EXT.
- R10: Any other index reads zero and a write to it changes no register; rdata_o is zero whenever rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| rd_en_i | input | 1 | Read strobe, data valid in the same cycle |
| addr_i | input | ADDR_W | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not reading |
| irq_o | output | 1 | Level interrupt |
| enabled_o | output | 1 | Enable and power both set |
| bpp_o | output | 3 | Pixel depth code |
| bgr_o | output | 1 | Colour component swap |
| be_byte_o | output | 1 | Big-endian byte order |
| be_pix_o | output | 1 | Big-endian pixel order within a byte |
| ppl_o | output | 11 | Active pixels per line |
| lpf_o | output | 11 | Lines per frame |

## Verification
The bench builds two copies side by side from the same bus stimulus: one with VAR_BASE and one with VAR_EXT, so that the swapped control and mask indices and both identification byte sets are checked in the same run. Both copies use TICK_CYCLES = 40 in place of the 60 Hz default. With that period, several frame ticks fit in a short run, along with a clear that lands exactly on a tick edge, a restart partway through a period, and the count to the first tick after enable.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  typedef enum logic [1:0] {
    VAR_BASE  = 2'd0,
    VAR_BOARD = 2'd1,
    VAR_EXT   = 2'd2
  } variant_e;

  localparam int DATA_W   = 32;
  localparam int NUM_TIM  = 4;
  localparam int DIM_W    = 11;

  // word indices
  localparam int IDX_TIM0  = 0;
  localparam int IDX_UPPER = 4;
  localparam int IDX_LOWER = 5;
  localparam int IDX_SLOTA = 6;
  localparam int IDX_SLOTB = 7;
  localparam int IDX_RAW   = 8;
  localparam int IDX_MSK   = 9;
  localparam int IDX_CLR   = 10;
  localparam int IDX_UPCUR = 11;
  localparam int IDX_LOCUR = 12;
  localparam int IDX_ID0   = 'h3F8;

  // control bits
  localparam int CB_EN   = 0;
  localparam int CB_BPP  = 1;
  localparam int CB_BGR  = 8;
  localparam int CB_BEB  = 9;
  localparam int CB_BEP  = 10;
  localparam int CB_PWR  = 11;

  // status bits
  localparam int SB_NB = 2;
  localparam int SB_VC = 3;

  function automatic int ctrl_idx(variant_e v);
    return (v == VAR_BASE) ? IDX_SLOTB : IDX_SLOTA;
  endfunction

  function automatic int mask_idx(variant_e v);
    return (v == VAR_BASE) ? IDX_SLOTA : IDX_SLOTB;
  endfunction

  function automatic logic [7:0] id_byte(variant_e v, logic [2:0] i);
    logic ext;
    ext = (v == VAR_EXT);
    case (i)
      3'd0:    return ext ? 8'h11 : 8'h10;
      3'd1:    return 8'h11;
      3'd2:    return ext ? 8'h24 : 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_cfg_regs.sv
module lcdc_cfg_regs
  import lcdc_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NTIM  = NUM_TIM,
  parameter int DIM_WIDTH = DIM_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DW-1:0]            wdata_i,
  input  logic [NTIM-1:0]          tim_we_i,
  input  logic                     up_we_i,
  input  logic                     lo_we_i,
  input  logic                     ctrl_we_i,
  input  logic                     mask_we_i,
  output logic [NTIM-1:0][DW-1:0]  tim_o,
  output logic [DW-1:0]            up_o,
  output logic [DW-1:0]            lo_o,
  output logic [DW-1:0]            ctrl_o,
  output logic [DW-1:0]            mask_o,
  output logic                     enabled_o,
  output logic [2:0]               bpp_o,
  output logic                     bgr_o,
  output logic                     be_byte_o,
  output logic                     be_pix_o,
  output logic [DIM_WIDTH-1:0]     ppl_o,
  output logic [DIM_WIDTH-1:0]     lpf_o
);

  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          tim_o[g] <= '0;
      else if (tim_we_i[g]) tim_o[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o   <= '0;
      lo_o   <= '0;
      ctrl_o <= '0;
      mask_o <= '0;
    end else begin
      if (up_we_i)   up_o   <= wdata_i;
      if (lo_we_i)   lo_o   <= wdata_i;
      if (ctrl_we_i) ctrl_o <= wdata_i;
      if (mask_we_i) mask_o <= wdata_i;
    end
  end

  assign enabled_o = ctrl_o[CB_EN] & ctrl_o[CB_PWR];
  assign bpp_o     = ctrl_o[CB_BPP +: 3];
  assign bgr_o     = ctrl_o[CB_BGR];
  assign be_byte_o = ctrl_o[CB_BEB];
  assign be_pix_o  = ctrl_o[CB_BEP];

  // ((t0 & 0xFC) + 4) * 4 == (t0[7:2] + 1) * 16
  logic [6:0] ppl_units;
  assign ppl_units = {1'b0, tim_o[0][7:2]} + 7'd1;
  assign ppl_o     = DIM_WIDTH'({ppl_units, 4'b0000});
  assign lpf_o     = DIM_WIDTH'({1'b0, tim_o[1][9:0]} + 11'd1);

endmodule

// File: rtl/lcdc_frame_irq.sv
module lcdc_frame_irq #(
  parameter int TICK_CYCLES = 1666667
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enabled_i,
  input  logic       restart_i,
  input  logic       clr_we_i,
  input  logic [1:0] clr_bits_i,
  input  logic [1:0] mask_bits_i,
  output logic [1:0] stat_o,
  output logic       tick_o,
  output logic       irq_o
);

  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = enabled_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (restart_i || !enabled_i || tick_o) cnt_q <= '0;
    else                                     cnt_q <= cnt_q + 1'b1;
  end

  logic [1:0] stat_d;
  always_comb begin
    stat_d = stat_o;
    if (clr_we_i) stat_d = stat_d & ~clr_bits_i;
    if (tick_o)   stat_d = 2'b11;  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= stat_d;
  end

  assign irq_o = |(stat_o & mask_bits_i);

endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int       ADDR_W      = 10,
  parameter variant_e VARIANT     = VAR_BASE,
  parameter int       TICK_CYCLES = 1666667
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              enabled_o,
  output logic [2:0]        bpp_o,
  output logic              bgr_o,
  output logic              be_byte_o,
  output logic              be_pix_o,
  output logic [10:0]       ppl_o,
  output logic [10:0]       lpf_o
);

  localparam int CTRL_IDX = ctrl_idx(VARIANT);
  localparam int MASK_IDX = mask_idx(VARIANT);
  localparam logic [ADDR_W-4:0] ID_HI = (ADDR_W-3)'(IDX_ID0 >> 3);

  // write decode
  logic [NUM_TIM-1:0] tim_we;
  logic up_we, lo_we, ctrl_we, mask_we, clr_we;

  for (genvar g = 0; g < NUM_TIM; g++) begin : g_twe
    assign tim_we[g] = wr_en_i && (addr_i == ADDR_W'(IDX_TIM0 + g));
  end
  assign up_we   = wr_en_i && (addr_i == ADDR_W'(IDX_UPPER));
  assign lo_we   = wr_en_i && (addr_i == ADDR_W'(IDX_LOWER));
  assign ctrl_we = wr_en_i && (addr_i == ADDR_W'(CTRL_IDX));
  assign mask_we = wr_en_i && (addr_i == ADDR_W'(MASK_IDX));
  assign clr_we  = wr_en_i && (addr_i == ADDR_W'(IDX_CLR));

  logic [NUM_TIM-1:0][31:0] tim_q;
  logic [31:0] up_q, lo_q, ctrl_q, mask_q;

  lcdc_cfg_regs #(
    .DW(32), .NTIM(NUM_TIM), .DIM_WIDTH(11)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (wdata_i),
    .tim_we_i  (tim_we),
    .up_we_i   (up_we),
    .lo_we_i   (lo_we),
    .ctrl_we_i (ctrl_we),
    .mask_we_i (mask_we),
    .tim_o     (tim_q),
    .up_o      (up_q),
    .lo_o      (lo_q),
    .ctrl_o    (ctrl_q),
    .mask_o    (mask_q),
    .enabled_o (enabled_o),
    .bpp_o     (bpp_o),
    .bgr_o     (bgr_o),
    .be_byte_o (be_byte_o),
    .be_pix_o  (be_pix_o),
    .ppl_o     (ppl_o),
    .lpf_o     (lpf_o)
  );

  logic [1:0] stat_q;
  logic       tick;

  lcdc_frame_irq #(
    .TICK_CYCLES(TICK_CYCLES)
  ) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enabled_i   (enabled_o),
    .restart_i   (ctrl_we),
    .clr_we_i    (clr_we),
    .clr_bits_i  (wdata_i[SB_VC:SB_NB]),
    .mask_bits_i (mask_q[SB_VC:SB_NB]),
    .stat_o      (stat_q),
    .tick_o      (tick),
    .irq_o       (irq_o)
  );

  // read mux
  logic [31:0] raw_word;
  assign raw_word = {28'd0, stat_q, 2'b00};

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i[ADDR_W-1:3] == ID_HI) begin
        rdata_o = {24'd0, id_byte(VARIANT, addr_i[2:0])};
      end else begin
        case (int'(addr_i))
          IDX_TIM0, IDX_TIM0 + 1, IDX_TIM0 + 2, IDX_TIM0 + 3:
                     rdata_o = tim_q[addr_i[1:0]];
          IDX_UPPER, IDX_UPCUR: rdata_o = up_q;
          IDX_LOWER, IDX_LOCUR: rdata_o = lo_q;
          CTRL_IDX:  rdata_o = ctrl_q;
          MASK_IDX:  rdata_o = mask_q;
          IDX_RAW:   rdata_o = raw_word;
          IDX_MSK:   rdata_o = raw_word & mask_q;
          default:   rdata_o = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk
  import lcdc_pkg::*;
#(
  parameter int       ADDR_W  = 10,
  parameter variant_e VARIANT = VAR_BASE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic              enabled_o,
  input logic [10:0]       ppl_o,
  input logic              tick_i,
  input logic [1:0]        stat_i
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(ctrl_idx(VARIANT));
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(IDX_CLR);
  localparam logic [ADDR_W-1:0] MSK_A  = ADDR_W'(IDX_MSK);

  // R3
  ppl_granule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppl_o[3:0] == 4'd0) && (ppl_o != 11'd0));

  // R4
  enable_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == CTRL_A) |=> (enabled_o == ($past(wdata_i[CB_EN]) && $past(wdata_i[CB_PWR]))));

  // R6
  no_tick_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_o |-> !tick_i);

  // R6
  tick_sets_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (stat_i == 2'b11));

  // R7
  irq_matches_mis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == MSK_A) |-> (irq_o == (rdata_o != 32'd0)));

  // R8
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == CLR_A && wdata_i[SB_NB] && !tick_i) |=> !stat_i[0]);

  // R10
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == 32'd0));

endmodule

bind lcdc_regs lcdc_regs_chk #(
  .ADDR_W  (ADDR_W),
  .VARIANT (VARIANT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .enabled_o (enabled_o),
  .ppl_o     (ppl_o),
  .tick_i    (tick),
  .stat_i    (stat_q)
);

// File: tb/sim_lcdc_regs.sv
`timescale 1ns/1ps
module sim_lcdc_regs;

  localparam int TICK  = 40;
  localparam int AW    = 10;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;

  always #5 clk = ~clk;

  logic [31:0] rdata_w [2];
  logic        irq_w [2], en_w [2], bgr_w [2], beb_w [2], bep_w [2];
  logic [2:0]  bpp_w [2];
  logic [10:0] ppl_w [2], lpf_w [2];

  lcdc_regs #(.ADDR_W(AW), .VARIANT(lcdc_pkg::VAR_BASE), .TICK_CYCLES(TICK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_w[0]), .irq_o(irq_w[0]), .enabled_o(en_w[0]),
    .bpp_o(bpp_w[0]), .bgr_o(bgr_w[0]), .be_byte_o(beb_w[0]), .be_pix_o(bep_w[0]),
    .ppl_o(ppl_w[0]), .lpf_o(lpf_w[0]));

  lcdc_regs #(.ADDR_W(AW), .VARIANT(lcdc_pkg::VAR_EXT), .TICK_CYCLES(TICK)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_w[1]), .irq_o(irq_w[1]), .enabled_o(en_w[1]),
    .bpp_o(bpp_w[1]), .bgr_o(bgr_w[1]), .be_byte_o(beb_w[1]), .be_pix_o(bep_w[1]),
    .ppl_o(ppl_w[1]), .lpf_o(lpf_w[1]));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(string req, int k, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s u%0d: actual %h expected %h (t=%0t)", req, k, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_tim [4];
  logic [31:0] m_up, m_lo;
  logic [31:0] m_ctrl [2], m_mask [2], m_stat [2];
  int          m_cnt [2];
  logic [7:0]  id_tab [2][8];

  initial begin
    id_tab[0] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    id_tab[1] = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
  end

  function automatic int ci(int k); return (k == 0) ? 7 : 6; endfunction
  function automatic int mi(int k); return (k == 0) ? 6 : 7; endfunction
  function automatic bit m_en(int k); return m_ctrl[k][0] && m_ctrl[k][11]; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_tim[i] = '0;
      m_up = '0; m_lo = '0;
      for (int k = 0; k < 2; k++) begin
        m_ctrl[k] = '0; m_mask[k] = '0; m_stat[k] = '0; m_cnt[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit restart, tk;
        restart = wr_en && (int'(addr) == ci(k));
        tk = m_en(k) && !restart && (m_cnt[k] == TICK - 1);
        if (restart || !m_en(k) || tk) m_cnt[k] = 0;
        else m_cnt[k] = m_cnt[k] + 1;
        if (wr_en && int'(addr) == 10) m_stat[k] = m_stat[k] & ~(wdata & 32'hC);
        if (tk) m_stat[k] = 32'hC;
        if (restart) m_ctrl[k] = wdata;
        if (wr_en && int'(addr) == mi(k)) m_mask[k] = wdata;
      end
      if (wr_en && int'(addr) < 4) m_tim[int'(addr)] = wdata;
      if (wr_en && int'(addr) == 4) m_up = wdata;
      if (wr_en && int'(addr) == 5) m_lo = wdata;
    end
  end

  function automatic logic [31:0] m_rd(int k, int a);
    if (!rd_en) return '0;
    if (a >= 'h3F8 && a <= 'h3FF) return {24'd0, id_tab[k][a - 'h3F8]};
    if (a < 4) return m_tim[a];
    if (a == 4 || a == 11) return m_up;
    if (a == 5 || a == 12) return m_lo;
    if (a == ci(k)) return m_ctrl[k];
    if (a == mi(k)) return m_mask[k];
    if (a == 8) return m_stat[k];
    if (a == 9) return m_stat[k] & m_mask[k];
    return '0;
  endfunction

  function automatic string rd_req(int a);
    if (!rd_en) return "R10";
    if (a < 6 || a == 11 || a == 12) return "R2";
    if (a == 6 || a == 7) return "R5";
    if (a == 8 || a == 9) return "R7";
    if (a >= 'h3F8) return "R9";
    return "R10";
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        chk(rd_req(int'(addr)), k, rdata_w[k], m_rd(k, int'(addr)));
        chk("R7", k, 32'(irq_w[k]), 32'(((m_stat[k] & m_mask[k]) != 0)));
        chk("R4", k, {27'd0, bep_w[k], beb_w[k], bgr_w[k], en_w[k]},
            {27'd0, m_ctrl[k][10], m_ctrl[k][9], m_ctrl[k][8], m_en(k)});
        chk("R4", k, 32'(bpp_w[k]), 32'(m_ctrl[k][3:1]));
        chk("R3", k, 32'(ppl_w[k]), ((m_tim[0] & 32'hFC) + 4) * 4);
        chk("R3", k, 32'(lpf_w[k]), (m_tim[1] & 32'h3FF) + 1);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    step();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(string req, int a, logic [31:0] e0, logic [31:0] e1);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    chk(req, 0, rdata_w[0], e0);
    chk(req, 1, rdata_w[1], e1);
    step();
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
      finish_run();
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk("R1", k, 32'(irq_w[k]), 0);
      chk("R1", k, 32'(en_w[k]), 0);
      chk("R1", k, 32'(ppl_w[k]), 16);
      chk("R1", k, 32'(lpf_w[k]), 1);
    end
    step();
    rd("R1", 8, 0, 0);
    rd("R1", 7, 0, 0);

    // R3 / R2 timing and bases
    wr(0, 32'h0000_00FC);
    @(negedge clk); chk("R3", 0, 32'(ppl_w[0]), 1024); step();
    wr(0, 32'hABCD_0027);
    wr(1, 32'hFFFF_FDDF);
    @(negedge clk);
    chk("R3", 0, 32'(ppl_w[0]), 160);
    chk("R3", 1, 32'(lpf_w[1]), 480);
    step();
    wr(2, 32'h1234_5678);
    wr(3, 32'h8765_4321);
    wr(4, 32'h0010_0000);
    wr(5, 32'h0020_0400);
    rd("R2", 0, 32'hABCD_0027, 32'hABCD_0027);
    rd("R2", 2, 32'h1234_5678, 32'h1234_5678);
    rd("R2", 3, 32'h8765_4321, 32'h8765_4321);
    rd("R2", 11, 32'h0010_0000, 32'h0010_0000);
    rd("R2", 12, 32'h0020_0400, 32'h0020_0400);

    // R5 swapped indices, R4 enable needs power
    wr(6, 32'h0000_000C);   // u0 mask, u1 control (no enable)
    wr(7, 32'h0000_0F0B);   // u0 control enabled, u1 mask; tick period starts
    @(negedge clk);
    chk("R4", 0, {29'd0, bpp_w[0]}, 5);
    chk("R4", 0, 32'(en_w[0]), 1);
    chk("R4", 1, 32'(en_w[1]), 0);
    chk("R4", 1, {29'd0, bpp_w[1]}, 6);
    step();
    rd("R5", 6, 32'h0000_000C, 32'h0000_000C);
    rd("R5", 7, 32'h0000_0F0B, 32'h0000_0F0B);
    // R6 first tick TICK edges after the control write (3 edges already used)
    repeat (TICK - 4) step();
    rd("R6", 8, 0, 0);
    rd("R6", 8, 32'hC, 0);
    rd("R7", 9, 32'hC, 0);
    @(negedge clk); chk("R7", 0, 32'(irq_w[0]), 1); step();

    // R8 clear by ones
    wr(10, 32'h0000_0004);
    rd("R8", 8, 32'h8, 0);
    wr(10, 32'hFFFF_FFF8);
    rd("R8", 8, 0, 0);
    @(negedge clk); chk("R8", 0, 32'(irq_w[0]), 0); step();

    // R8 clear on the tick edge: set wins
    while (m_cnt[0] != TICK - 1) step();
    wr(10, 32'h0000_000C);
    rd("R8", 8, 32'hC, 0);

    // R7 masked off while status set
    wr(6, 32'h0000_0000);
    rd("R7", 9, 0, 0);
    @(negedge clk); chk("R7", 0, 32'(irq_w[0]), 0); step();

    // R6 disabled: no ticks
    wr(7, 32'h0000_0001);
    wr(10, 32'hC);
    repeat (3 * TICK) step();
    rd("R6", 8, 0, 0);

    // R6 restart mid-period
    wr(7, 32'h0000_0801);
    repeat (30) step();
    wr(7, 32'h0000_0801);
    repeat (TICK - 1) step();
    rd("R6", 8, 0, 0);
    rd("R6", 8, 32'hC, 0);
    wr(10, 32'hC);

    // u1 enable via index 6
    wr(6, 32'h0000_0803);
    repeat (TICK + 2) step();
    rd("R6", 8, 32'hC, 32'hC);

    // R9 identification bytes
    for (int i = 0; i < 8; i++)
      rd("R9", 'h3F8 + i, {24'd0, id_tab[0][i]}, {24'd0, id_tab[1][i]});

    // R10 undefined indices
    wr(13, 32'hFFFF_FFFF);
    wr('h100, 32'hFFFF_FFFF);
    rd("R10", 13, 0, 0);
    rd("R10", 'h100, 0, 0);
    rd("R10", 4, 32'h0010_0000, 32'h0010_0000);
    addr = AW'(4);
    @(negedge clk); chk("R10", 0, rdata_w[0], 0); step();

    repeat (5) step();
    finish_run();
  end

endmodule